// File: doc/BRIEF.md
# Program Fetch Source Selector

This block sits between a processor core's instruction fetch stage and two program stores: an on-chip code array and an off-chip program bus. A strap input is read while reset is held, and the value it has on the final reset edge fixes the fetch source until the next reset. In internal mode, every fetch below the top of the on-chip array goes to the array. Fetches into the 2 KB window above the array are answered with a NOP opcode, and the off-chip bus is never touched for them. In external mode, every fetch at any address goes to the off-chip bus.

The core issues one request per cycle, with a strobe and a 16-bit address. Each read port is a synchronous store: it takes an enable and an address in one cycle and returns its byte in the next cycle. The response to the core, a valid flag and a byte, therefore appears exactly one cycle after the request, whichever source served it. A mode output reports the latched selection.

Top module: `code_fetch_router`

## Requirements
- R1: While reset (`rstN` low) is asserted, `fetchValid`, `intRdEn` and `extRdEn` are all 0, even if `fetchReq` is 1.
- R2: `extMode` equals the inverse of `extStrapN` as sampled on the last clock edge with `rstN` low. Changes on `extStrapN` after reset is released do not alter `extMode` or the routing of fetches.
- R3: In internal mode (`extMode` = 0), a request with an address from 0000H to F7FFH asserts `intRdEn` in the same cycle, with `intRdAddr` equal to the request address. `extRdEn` stays 0.
- R4: In internal mode, a request with an address from F800H to FFFFH asserts neither read enable. It is answered with `fetchData` = 8'h00, the NOP opcode.
- R5: In external mode (`extMode` = 1), a request at any address from 0000H to FFFFH asserts `extRdEn`, with `extRdAddr` equal to the request address. `intRdEn` stays 0.
- R6: `fetchValid` is 1 in the cycle after a request. In that cycle, `fetchData` is the byte returned by the selected read port, or the NOP opcode when R4 applies.
- R7: A cycle with `fetchReq` = 0 asserts no read enable, and `fetchValid` is 0 in the following cycle.
- R8: Requests on consecutive cycles, including ones that switch between the array and the NOP window, each get their own response in issue order, with no cycle lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| extStrapN | input | 1 | Strap input; low while in reset selects the off-chip program source |
| fetchReq | input | 1 | Fetch request strobe from the core |
| fetchAddr | input | 16 | Fetch address |
| fetchValid | output | 1 | Response valid, one cycle after the request |
| fetchData | output | 8 | Fetched opcode byte |
| extMode | output | 1 | Latched source selection: 1 = off-chip, 0 = on-chip |
| intRdEn | output | 1 | On-chip array read enable |
| intRdAddr | output | 16 | On-chip array read address |
| intRdData | input | 8 | On-chip array read data, one cycle after enable |
| extRdEn | output | 1 | Off-chip bus read enable |
| extRdAddr | output | 16 | Off-chip bus read address |
| extRdData | input | 8 | Off-chip bus read data, one cycle after enable |

## Verification
The hardest situation to reach is the one where the strap input moves after reset has been released. The latched mode must not follow it, and no fetch in the NOP window may leak onto the off-chip bus. To cover this, the stimulus runs two reset episodes with opposite strap levels. After each release it flips the strap and keeps it flipped while fetches are issued at the window edges F7FFH/F800H and at FFFFH. It then checks the enables in the request cycle and the returned byte in the next cycle, in back-to-back order.

// File: rtl/fetch_route_pkg.sv
package fetch_route_pkg;

  // Strobes from control to datapath, one request cycle
  typedef struct packed {
    logic intRd;    // serve from on-chip array
    logic extRd;    // serve from off-chip bus
    logic nopFill;  // answer with the NOP opcode
  } fetch_strb_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_INT  = 2'd1,
    SEL_EXT  = 2'd2,
    SEL_NOP  = 2'd3
  } resp_sel_e;

endpackage

// File: rtl/fetch_route_ctrl.sv
module fetch_route_ctrl
  import fetch_route_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INT_LIMIT = 16'hF800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extStrapN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output fetch_strb_t       strb,
  output logic              extMode
);

  logic extModeQ;
  logic addrInArray;
  logic reqLive;

  // Strap tracked while reset holds; the last reset edge's value sticks
  always_ff @(posedge clk) begin
    if (!rstN) extModeQ <= ~extStrapN;
  end

  assign extMode     = extModeQ;
  assign addrInArray = (fetchAddr < INT_LIMIT);
  assign reqLive     = rstN & fetchReq;

  always_comb begin
    strb         = '0;
    strb.extRd   = reqLive &  extModeQ;
    strb.intRd   = reqLive & ~extModeQ &  addrInArray;
    strb.nopFill = reqLive & ~extModeQ & ~addrInArray;
  end

  // R2: selection frozen once out of reset
  p_mode_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(extModeQ));

  // R3: at most one source chosen per request
  p_one_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.intRd, strb.extRd, strb.nopFill}));

  // R4: internal mode never drives the off-chip bus
  p_no_ext_internal_r4: assert property (@(posedge clk) disable iff (!rstN)
    !extModeQ |-> !strb.extRd);

  // R5: external mode sends every request off-chip
  p_ext_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (extModeQ && fetchReq) |-> (strb.extRd && !strb.intRd && !strb.nopFill));

endmodule

// File: rtl/fetch_route_dp.sv
module fetch_route_dp
  import fetch_route_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] NOP_CODE = 8'h00,
  parameter bit GATE_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetch_strb_t       strb,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              intRdEn,
  output logic [ADDR_W-1:0] intRdAddr,
  input  logic [DATA_W-1:0] intRdData,
  output logic              extRdEn,
  output logic [ADDR_W-1:0] extRdAddr,
  input  logic [DATA_W-1:0] extRdData,
  output logic              fetchValid,
  output logic [DATA_W-1:0] fetchData
);

  resp_sel_e respSel;
  logic      anyStrb;

  assign intRdEn = strb.intRd;
  assign extRdEn = strb.extRd;
  assign anyStrb = strb.intRd | strb.extRd | strb.nopFill;

  generate
    if (GATE_ADDR) begin : g_gated
      // Idle ports see a zero address to cut pad toggling
      assign intRdAddr = strb.intRd ? fetchAddr : '0;
      assign extRdAddr = strb.extRd ? fetchAddr : '0;
    end else begin : g_open
      assign intRdAddr = fetchAddr;
      assign extRdAddr = fetchAddr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respSel <= SEL_NONE;
    end else if (strb.intRd) begin
      respSel <= SEL_INT;
    end else if (strb.extRd) begin
      respSel <= SEL_EXT;
    end else if (strb.nopFill) begin
      respSel <= SEL_NOP;
    end else begin
      respSel <= SEL_NONE;
    end
  end

  assign fetchValid = (respSel != SEL_NONE);

  always_comb begin
    case (respSel)
      SEL_INT: fetchData = intRdData;
      SEL_EXT: fetchData = extRdData;
      default: fetchData = NOP_CODE;
    endcase
  end

  // R6: every accepted request answered next cycle
  p_resp_next_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyStrb |=> fetchValid);

  // R4: window fetches return the NOP opcode
  p_nop_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.nopFill |=> (fetchData == NOP_CODE));

  // R7: idle cycle gives no response
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !anyStrb |=> !fetchValid);

endmodule

// File: rtl/code_fetch_router.sv
module code_fetch_router
  import fetch_route_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] INT_LIMIT = 16'hF800,
  parameter logic [DATA_W-1:0] NOP_CODE = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extStrapN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchValid,
  output logic [DATA_W-1:0] fetchData,
  output logic              extMode,
  output logic              intRdEn,
  output logic [ADDR_W-1:0] intRdAddr,
  input  logic [DATA_W-1:0] intRdData,
  output logic              extRdEn,
  output logic [ADDR_W-1:0] extRdAddr,
  input  logic [DATA_W-1:0] extRdData
);

  fetch_strb_t strb;

  fetch_route_ctrl #(
    .ADDR_W(ADDR_W),
    .INT_LIMIT(INT_LIMIT)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .extStrapN(extStrapN),
    .fetchReq(fetchReq),
    .fetchAddr(fetchAddr),
    .strb(strb),
    .extMode(extMode)
  );

  fetch_route_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NOP_CODE(NOP_CODE),
    .GATE_ADDR(1'b1)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .fetchAddr(fetchAddr),
    .intRdEn(intRdEn),
    .intRdAddr(intRdAddr),
    .intRdData(intRdData),
    .extRdEn(extRdEn),
    .extRdAddr(extRdAddr),
    .extRdData(extRdData),
    .fetchValid(fetchValid),
    .fetchData(fetchData)
  );

  // R1: nothing leaves the block while reset holds
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (!intRdEn && !extRdEn));

endmodule

// File: tb/code_fetch_router_tb.sv
module code_fetch_router_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extStrapN = 1'b1;
  logic        fetchReq = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic        fetchValid;
  logic [7:0]  fetchData;
  logic        extMode;
  logic        intRdEn, extRdEn;
  logic [15:0] intRdAddr, extRdAddr;
  logic [7:0]  intRdData, extRdData;

  int checks = 0;
  int failures = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  typedef struct {
    bit       vld;
    bit [7:0] data;
    int       req;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;

  code_fetch_router u_dut (
    .clk(clk), .rstN(rstN), .extStrapN(extStrapN),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchData(fetchData), .extMode(extMode),
    .intRdEn(intRdEn), .intRdAddr(intRdAddr), .intRdData(intRdData),
    .extRdEn(extRdEn), .extRdAddr(extRdAddr), .extRdData(extRdData)
  );

  function automatic logic [7:0] intByte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] extByte(logic [15:0] a);
    return a[7:0] + a[15:8] + 8'hA3;
  endfunction

  // Synchronous store models; an unenabled read yields a marker byte
  always_ff @(posedge clk) begin
    intRdData <= intRdEn ? intByte(intRdAddr) : 8'hEE;
    extRdData <= extRdEn ? extByte(extRdAddr) : 8'hDD;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one cycle per call, checks enables, queues the response
  task automatic drive(input bit req, input logic [15:0] a, input int reqNo);
    exp_t e;
    @(negedge clk);
    fetchReq  = req;
    fetchAddr = a;
    #1;
    e.req = reqNo;
    e.vld = req;
    e.data = 8'h00;
    if (!req) begin
      check(!intRdEn && !extRdEn, "R7 enables idle", {intRdEn, extRdEn}, 0);
    end else if (extMode) begin
      check(extRdEn && !intRdEn && extRdAddr == a, "R5 off-chip route",
            {extRdEn, intRdEn, extRdAddr}, {2'b10, a});
      e.data = extByte(a);
    end else if (a < 16'hF800) begin
      check(intRdEn && !extRdEn && intRdAddr == a, "R3 on-chip route",
            {intRdEn, extRdEn, intRdAddr}, {2'b10, a});
      e.data = intByte(a);
    end else begin
      check(!intRdEn && !extRdEn, "R4 window no enable", {intRdEn, extRdEn}, 0);
    end
    expQ.push_back(e);
  endtask

  // Monitor: response visible shortly after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (monOn && expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(fetchValid == e.vld, $sformatf("R%0d valid", e.req), fetchValid, e.vld);
        if (e.vld)
          check(fetchData == e.data, $sformatf("R%0d data (R6/R8)", e.req), fetchData, e.data);
      end
    end
  end

  task automatic doReset(input bit strapN);
    @(negedge clk);
    monOn = 1'b0;
    rstN = 1'b0;
    extStrapN = strapN;
    fetchReq = 1'b1;
    fetchAddr = 16'h0100;
    repeat (3) begin
      @(negedge clk);
      #1;
      // R1: quiet during reset even with a request pending
      check(!intRdEn && !extRdEn, "R1 enables in reset", {intRdEn, extRdEn}, 0);
      check(!fetchValid, "R1 valid in reset", fetchValid, 0);
    end
    rstN = 1'b1;
    fetchReq = 1'b0;
    // R2: flip the strap right after release
    extStrapN = ~strapN;
    @(negedge clk);
    check(extMode == !strapN, "R2 mode latched", extMode, !strapN);
    monOn = 1'b1;
  endtask

  initial begin
    // Internal mode
    doReset(1'b1);
    drive(1'b1, 16'h0000, 3);
    drive(1'b1, 16'hF7FF, 3);
    drive(1'b1, 16'hF800, 4);
    drive(1'b1, 16'hFFFF, 4);
    drive(1'b0, 16'h1234, 7);
    drive(1'b1, 16'h1234, 8);   // R8: array, window, array back-to-back
    drive(1'b1, 16'hFABC, 8);
    drive(1'b1, 16'h7F00, 8);
    drive(1'b0, 16'h0000, 7);
    drive(1'b0, 16'h0000, 7);
    check(extMode == 1'b0, "R2 mode held after strap change", extMode, 0);

    // External mode
    doReset(1'b0);
    drive(1'b1, 16'h0000, 5);
    drive(1'b1, 16'hF7FF, 5);
    drive(1'b1, 16'hF800, 5);
    drive(1'b1, 16'hFFFF, 5);
    for (int a = 0; a < 65536; a += 16'h0FFF) drive(1'b1, a[15:0], 5);
    drive(1'b0, 16'h0000, 7);
    drive(1'b0, 16'h0000, 7);
    check(extMode == 1'b1, "R2 mode held after strap change", extMode, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule